// File: doc/BRIEF.md
# Byte-Masked Dual-Port Block Memory

This block is an on-chip RAM with two ports and 4,608 storage cells. Every port has its own clock, a synchronous clear for its read register, an address input, write data, a write strobe, byte-lane enables and a hold input that freezes the captured address. A parameter picks the word shape. Shapes whose width is a multiple of nine carry a ninth bit in every lane and use the whole 4,608 cells. The other shapes use 4,096 cells. With a second parameter the B port becomes a read-only port. That mode is the only one that accepts the two widest shapes.

A port registers all of its inputs on a rising clock edge. The array is read and written on the next edge of that port, and the read register loads on that edge too. An optional extra output stage adds one more cycle. A read on the port that is writing returns the word after the write. A read from the other port returns the word as it was before the write. If both ports write the same word in the same cycle, the stored result is undefined.

Top module: `dp_bram`

## Requirements
- R1: The WIDTH parameter must be 1, 2, 4, 8, 9, 16, 18, 32 or 36. DEPTH is 4608/WIDTH for widths that are multiples of 9 and 4096/WIDTH for the others. Addresses are clog2(DEPTH) bits wide. Every address from 0 to DEPTH-1 is a separate word. Widths 32 and 36 fail elaboration unless TRUE_DUAL is 0.
- R2: Enable bit i covers data bits [i*L +: L], where L is 9 for widths that are multiples of 9 and 8 otherwise. Widths below 8 have one enable bit that covers the whole word. On a write, bits under a cleared enable keep their old contents.
- R3: Inputs presented before rising edge k have their effect at edge k+1, and the read register shows the result after edge k+1. With OUT_REG=1 the result shows after edge k+2.
- R4: When the hold input is high at an edge, the port's captured address keeps its previous value. Reads and writes in that period use the held address.
- R5: A port that reads the word it is writing in the same access returns the new word. Lanes that are masked off return their old contents.
- R6: A port that reads a word while the other port writes it, in the same edge, returns the contents from before the write.
- R7: A clear sampled high at an edge sets that port's output to zero after that edge. The array contents and the captured address are left as they were.
- R8: Both outputs are zero from power-up until the first access completes.
- R9: With TRUE_DUAL=0, writes on port B have no effect on the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| clr_a | input | 1 | Port A output register clear |
| addr_hold_a | input | 1 | Port A address hold |
| addr_a | input | AW | Port A address |
| din_a | input | WIDTH | Port A write data |
| be_a | input | NBE | Port A lane enables |
| we_a | input | 1 | Port A write strobe |
| q_a | output | WIDTH | Port A read data |
| clk_b | input | 1 | Port B clock |
| clr_b | input | 1 | Port B output register clear |
| addr_hold_b | input | 1 | Port B address hold |
| addr_b | input | AW | Port B address |
| din_b | input | WIDTH | Port B write data |
| be_b | input | NBE | Port B lane enables |
| we_b | input | 1 | Port B write strobe |
| q_b | output | WIDTH | Port B read data |

## Verification
The bench runs a write on one port and a read of the same word on the other port in the same cycle. A design that bypasses the new data across ports would return the new word there instead of the old one. It runs partial-lane writes on a word while the same port reads it, which catches a design that returns only the raw write data or the stale word. It keeps the hold input high while the address input changes and a write is issued, so a design that ignores the hold reads or corrupts the wrong word. It also clears the output and then checks that the same word comes back with no new address. A design that resets the address or the array on a clear fails that check.

// File: rtl/dp_bram.sv
module dp_bram #(
  parameter int WIDTH     = 9,
  parameter bit TRUE_DUAL = 1'b1,
  parameter bit OUT_REG   = 1'b0,
  localparam int LANE  = (WIDTH % 9 == 0) ? 9 : ((WIDTH < 8) ? WIDTH : 8),
  localparam int NBE   = WIDTH / LANE,
  localparam int DEPTH = (WIDTH % 9 == 0) ? 4608 / WIDTH : 4096 / WIDTH,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic             clk_a,
  input  logic             clr_a,
  input  logic             addr_hold_a,
  input  logic [AW-1:0]    addr_a,
  input  logic [WIDTH-1:0] din_a,
  input  logic [NBE-1:0]   be_a,
  input  logic             we_a,
  output logic [WIDTH-1:0] q_a,
  input  logic             clk_b,
  input  logic             clr_b,
  input  logic             addr_hold_b,
  input  logic [AW-1:0]    addr_b,
  input  logic [WIDTH-1:0] din_b,
  input  logic [NBE-1:0]   be_b,
  input  logic             we_b,
  output logic [WIDTH-1:0] q_b
);

  localparam bit SHAPE_OK = (WIDTH == 1) || (WIDTH == 2) || (WIDTH == 4) ||
                            (WIDTH == 8) || (WIDTH == 9) || (WIDTH == 16) ||
                            (WIDTH == 18) || (WIDTH == 32) || (WIDTH == 36);

  if (!SHAPE_OK) begin : g_bad_shape
    $error("dp_bram: WIDTH %0d is not a supported shape", WIDTH);
  end
  if (TRUE_DUAL && WIDTH >= 32) begin : g_bad_dual
    $error("dp_bram: WIDTH %0d needs TRUE_DUAL = 0", WIDTH);
  end

  function automatic logic [WIDTH-1:0] lanes(input logic [NBE-1:0] be);
    logic [WIDTH-1:0] m;
    m = '0;
    for (int i = 0; i < NBE; i++) m[i*LANE +: LANE] = {LANE{be[i]}};
    return m;
  endfunction

  // Two banks, each written by one port only; a word is the XOR of both.
  logic [WIDTH-1:0] bank_a [DEPTH];
  logic [WIDTH-1:0] bank_b [DEPTH];

  logic [AW-1:0]    aq_a = '0, aq_b = '0;
  logic [WIDTH-1:0] dq_a = '0, dq_b = '0;
  logic [NBE-1:0]   bq_a = '0, bq_b = '0;
  logic             wq_a = 1'b0, wq_b = 1'b0;
  logic [WIDTH-1:0] q1_a = '0, q1_b = '0;

  always_ff @(posedge clk_a) begin
    aq_a <= addr_hold_a ? aq_a : addr_a;
    dq_a <= din_a;
    bq_a <= be_a;
    wq_a <= we_a;
  end

  always_ff @(posedge clk_b) begin
    aq_b <= addr_hold_b ? aq_b : addr_b;
    dq_b <= din_b;
    bq_b <= be_b;
    wq_b <= TRUE_DUAL ? we_b : 1'b0;
  end

  wire [WIDTH-1:0] oth_a = TRUE_DUAL ? bank_b[aq_a] : '0;
  wire [WIDTH-1:0] oth_b = TRUE_DUAL ? bank_b[aq_b] : '0;
  wire [WIDTH-1:0] cur_a = bank_a[aq_a] ^ oth_a;
  wire [WIDTH-1:0] cur_b = bank_a[aq_b] ^ oth_b;
  wire [WIDTH-1:0] msk_a = lanes(bq_a) & {WIDTH{wq_a}};
  wire [WIDTH-1:0] msk_b = lanes(bq_b) & {WIDTH{wq_b}};
  wire [WIDTH-1:0] new_a = (dq_a & msk_a) | (cur_a & ~msk_a);
  wire [WIDTH-1:0] new_b = (dq_b & msk_b) | (cur_b & ~msk_b);

  always_ff @(posedge clk_a) begin
    if (wq_a) bank_a[aq_a] <= new_a ^ oth_a;
    q1_a <= clr_a ? '0 : new_a;
  end

  always_ff @(posedge clk_b) begin
    if (wq_b) bank_b[aq_b] <= new_b ^ bank_a[aq_b];
    q1_b <= clr_b ? '0 : new_b;
  end

  if (OUT_REG) begin : g_oreg
    logic [WIDTH-1:0] q2_a = '0, q2_b = '0;
    always_ff @(posedge clk_a) q2_a <= clr_a ? '0 : q1_a;
    always_ff @(posedge clk_b) q2_b <= clr_b ? '0 : q1_b;
    assign q_a = q2_a;
    assign q_b = q2_b;
  end else begin : g_direct
    assign q_a = q1_a;
    assign q_b = q1_b;
  end

endmodule

// File: rtl/dp_bram_chk.sv
module dp_bram_chk #(
  parameter int WIDTH   = 9,
  parameter bit OUT_REG = 1'b0
) (
  input logic             clk_a,
  input logic             clk_b,
  input logic             clr_a,
  input logic             clr_b,
  input logic             we_a,
  input logic             we_b,
  input logic             addr_hold_a,
  input logic             addr_hold_b,
  input logic [WIDTH-1:0] q_a,
  input logic [WIDTH-1:0] q_b
);

  logic [2:0] cnt_a = '0, cnt_b = '0;
  always_ff @(posedge clk_a) if (cnt_a != 3'd7) cnt_a <= cnt_a + 3'd1;
  always_ff @(posedge clk_b) if (cnt_b != 3'd7) cnt_b <= cnt_b + 3'd1;
  wire arm_a = (cnt_a >= 3'd6);
  wire arm_b = (cnt_b >= 3'd6);

  a_r7_clear_a: assert property (@(posedge clk_a) disable iff (!arm_a)
    clr_a |=> (q_a == '0));
  a_r7_clear_b: assert property (@(posedge clk_b) disable iff (!arm_b)
    clr_b |=> (q_b == '0));

  // R4: held address, no writes and no clear leave the output unchanged.
  // The cross-port term assumes both ports share one clock.
  if (OUT_REG) begin : g_hold2
    a_r4_hold_a: assert property (@(posedge clk_a) disable iff (!arm_a)
      ($past(addr_hold_a, 3) && !$past(we_a, 3) && !$past(we_a, 4) && !$past(we_b, 4) &&
       !$past(clr_a, 1) && !$past(clr_a, 2) && !$past(clr_a, 3)) |-> $stable(q_a));
    a_r4_hold_b: assert property (@(posedge clk_b) disable iff (!arm_b)
      ($past(addr_hold_b, 3) && !$past(we_b, 3) && !$past(we_b, 4) && !$past(we_a, 4) &&
       !$past(clr_b, 1) && !$past(clr_b, 2) && !$past(clr_b, 3)) |-> $stable(q_b));
  end else begin : g_hold1
    a_r4_hold_a: assert property (@(posedge clk_a) disable iff (!arm_a)
      ($past(addr_hold_a, 2) && !$past(we_a, 2) && !$past(we_a, 3) && !$past(we_b, 3) &&
       !$past(clr_a, 1) && !$past(clr_a, 2)) |-> $stable(q_a));
    a_r4_hold_b: assert property (@(posedge clk_b) disable iff (!arm_b)
      ($past(addr_hold_b, 2) && !$past(we_b, 2) && !$past(we_b, 3) && !$past(we_a, 3) &&
       !$past(clr_b, 1) && !$past(clr_b, 2)) |-> $stable(q_b));
  end

endmodule

bind dp_bram dp_bram_chk #(.WIDTH(WIDTH), .OUT_REG(OUT_REG)) u_chk (
  .clk_a(clk_a), .clk_b(clk_b), .clr_a(clr_a), .clr_b(clr_b),
  .we_a(we_a), .we_b(we_b), .addr_hold_a(addr_hold_a), .addr_hold_b(addr_hold_b),
  .q_a(q_a), .q_b(q_b));

// File: tb/sim_dp_bram.sv
module sim_dp_bram;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;

  // u0: 256 x 18, both ports read/write, no extra stage
  logic a0_clr = 0, a0_hold = 0, a0_we = 0, b0_clr = 0, b0_hold = 0, b0_we = 0;
  logic [7:0]  a0_addr = '0, b0_addr = '0;
  logic [17:0] a0_din = '0, b0_din = '0, a0_q, b0_q;
  logic [1:0]  a0_be = '1, b0_be = '1;

  // u1: 128 x 36, port B read-only, extra output stage
  logic a1_clr = 0, a1_hold = 0, a1_we = 0, b1_clr = 0, b1_hold = 0, b1_we = 0;
  logic [6:0]  a1_addr = '0, b1_addr = '0;
  logic [35:0] a1_din = '0, b1_din = '0, a1_q, b1_q;
  logic [3:0]  a1_be = '1, b1_be = '1;

  dp_bram #(.WIDTH(18), .TRUE_DUAL(1'b1), .OUT_REG(1'b0)) u0 (
    .clk_a(clk), .clr_a(a0_clr), .addr_hold_a(a0_hold), .addr_a(a0_addr), .din_a(a0_din),
    .be_a(a0_be), .we_a(a0_we), .q_a(a0_q),
    .clk_b(clk), .clr_b(b0_clr), .addr_hold_b(b0_hold), .addr_b(b0_addr), .din_b(b0_din),
    .be_b(b0_be), .we_b(b0_we), .q_b(b0_q));

  dp_bram #(.WIDTH(36), .TRUE_DUAL(1'b0), .OUT_REG(1'b1)) u1 (
    .clk_a(clk), .clr_a(a1_clr), .addr_hold_a(a1_hold), .addr_a(a1_addr), .din_a(a1_din),
    .be_a(a1_be), .we_a(a1_we), .q_a(a1_q),
    .clk_b(clk), .clr_b(b1_clr), .addr_hold_b(b1_hold), .addr_b(b1_addr), .din_b(b1_din),
    .be_b(b1_be), .we_b(b1_we), .q_b(b1_q));

  task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic go(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr0a(input logic [7:0] ad, input logic [17:0] d, input logic [1:0] be);
    a0_addr = ad; a0_din = d; a0_be = be; a0_we = 1; go(1); a0_we = 0;
  endtask
  task automatic wr0b(input logic [7:0] ad, input logic [17:0] d, input logic [1:0] be);
    b0_addr = ad; b0_din = d; b0_be = be; b0_we = 1; go(1); b0_we = 0;
  endtask
  task automatic rd0a(input logic [7:0] ad, output logic [17:0] v);
    a0_addr = ad; go(2); v = a0_q;
  endtask
  task automatic rd0b(input logic [7:0] ad, output logic [17:0] v);
    b0_addr = ad; go(2); v = b0_q;
  endtask
  task automatic wr1a(input logic [6:0] ad, input logic [35:0] d, input logic [3:0] be);
    a1_addr = ad; a1_din = d; a1_be = be; a1_we = 1; go(1); a1_we = 0;
  endtask
  task automatic rd1b(input logic [6:0] ad, output logic [35:0] v);
    b1_addr = ad; go(3); v = b1_q;
  endtask

  task automatic t_powerup;
    chk("R8 q_a power-up", 36'(a0_q), 36'h0);
    chk("R8 q_b power-up", 36'(b0_q), 36'h0);
    chk("R8 wide q_b power-up", b1_q, 36'h0);
  endtask

  task automatic t_shape;
    logic [17:0] v;
    wr0a(8'd255, 18'h2468A, 2'b11);
    wr0a(8'd0, 18'h13579, 2'b11);
    rd0a(8'd255, v); chk("R1 top word", 36'(v), 36'h2468A);
    rd0a(8'd0, v);   chk("R1 bottom word", 36'(v), 36'h13579);
  endtask

  task automatic t_lanes;
    logic [17:0] v;
    wr0a(8'd5, 18'h3FFFF, 2'b11);
    wr0a(8'd5, 18'h00000, 2'b01);
    rd0a(8'd5, v); chk("R2 low lane only", 36'(v), 36'h3FE00);
    wr0a(8'd5, 18'h15555, 2'b10);
    rd0a(8'd5, v); chk("R2 high lane only", 36'(v), 36'h15400);
    wr0a(8'd5, 18'h3FFFF, 2'b00);
    rd0a(8'd5, v); chk("R2 no lanes", 36'(v), 36'h15400);
  endtask

  task automatic t_latency;
    logic [17:0] v;
    wr0a(8'd6, 18'h00123, 2'b11);
    rd0a(8'd5, v);
    a0_addr = 8'd6; go(1);
    chk("R3 one edge: old word", 36'(a0_q), 36'h15400);
    go(1);
    chk("R3 two edges: new word", 36'(a0_q), 36'h00123);
  endtask

  task automatic t_hold;
    logic [17:0] v;
    wr0a(8'd9, 18'h11111, 2'b11);
    rd0a(8'd6, v);
    a0_hold = 1; a0_addr = 8'd5; go(3);
    chk("R4 held read", 36'(a0_q), 36'h00123);
    a0_addr = 8'd9; a0_din = 18'h2AAAA; a0_be = 2'b11; a0_we = 1; go(1);
    a0_we = 0; a0_hold = 0;
    rd0a(8'd6, v); chk("R4 write went to held word", 36'(v), 36'h2AAAA);
    rd0a(8'd9, v); chk("R4 input word untouched", 36'(v), 36'h11111);
  endtask

  task automatic t_same_port;
    wr0a(8'd7, 18'h3FFFF, 2'b11);
    a0_addr = 8'd7; a0_din = 18'h00000; a0_be = 2'b01; a0_we = 1; go(1);
    a0_we = 0; go(1);
    chk("R5 same-port read sees new merged word", 36'(a0_q), 36'h3FE00);
  endtask

  task automatic t_mixed;
    logic [17:0] v;
    wr0b(8'd10, 18'h0F0F0, 2'b11);
    rd0a(8'd10, v); chk("R6 B write visible on A", 36'(v), 36'h0F0F0);
    wr0a(8'd8, 18'h01234, 2'b11);
    go(1);
    b0_addr = 8'd8; a0_addr = 8'd8; a0_din = 18'h3ABCD; a0_be = 2'b11; a0_we = 1; go(1);
    a0_we = 0; go(1);
    chk("R6 cross-port read sees old word", 36'(b0_q), 36'h01234);
    go(1);
    chk("R6 next read sees new word", 36'(b0_q), 36'h3ABCD);
  endtask

  task automatic t_clear;
    logic [17:0] v;
    rd0a(8'd8, v);
    a0_clr = 1; go(1);
    chk("R7 output cleared", 36'(a0_q), 36'h0);
    chk("R7 other port untouched", 36'(b0_q), 36'h3ABCD);
    a0_clr = 0; go(1);
    chk("R7 address and array kept", 36'(a0_q), 36'h3ABCD);
  endtask

  task automatic t_collision;
    a0_addr = 8'd20; b0_addr = 8'd20; a0_din = 18'h1; b0_din = 18'h2;
    a0_we = 1; b0_we = 1; go(1);
    a0_we = 0; b0_we = 0; go(2);
    $display("NOTE: both ports wrote word 20 together; its contents are not checked");
  endtask

  task automatic t_wide;
    logic [35:0] v;
    wr1a(7'd3, 36'h123456789, 4'hF);
    wr1a(7'd4, 36'hFEDCBA987, 4'hF);
    rd1b(7'd3, v); chk("R3 extra stage read", v, 36'h123456789);
    b1_addr = 7'd4; go(2);
    chk("R3 extra stage: two edges still old", b1_q, 36'h123456789);
    go(1);
    chk("R3 extra stage: three edges new", b1_q, 36'hFEDCBA987);
    b1_addr = 7'd3; b1_din = 36'h0; b1_be = 4'hF; b1_we = 1; go(1); b1_we = 0;
    rd1b(7'd3, v); chk("R9 read-only port write ignored", v, 36'h123456789);
    wr1a(7'd3, 36'h0, 4'b0010);
    rd1b(7'd3, v); chk("R2 nine-bit lane 1 cleared", v, 36'h123440189);
  endtask

  initial begin
    #1;
    t_powerup();
    go(1);
    t_shape();
    t_lanes();
    t_latency();
    t_hold();
    t_same_port();
    t_mixed();
    t_clear();
    t_collision();
    t_wide();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule